// File: doc/BRIEF.md
# MSI message ring-buffer collector

The collector accepts inbound message-signalled interrupt writes, each carrying a 32-bit data word. It logs every accepted message as a 16-byte entry in a circular buffer that lives in system memory. Entries go out through a memory write request port with a valid/ready handshake. Only one write is in flight at a time, and a single-entry holding register sits between the message input and the memory port.

Software sets the block up through a small word-addressed register file. It holds a control word, a 64-bit buffer base address split into two halves, a software-owned read offset and a hardware-owned write offset. The ring size is chosen from four power-of-two sizes. With the default parameter these are 32, 64, 128 and 256 KB. A level interrupt stays asserted while unread entries exist.

When the ring is full, the block can do one of two things: stall incoming messages, or drop them and raise a sticky overflow flag.

Top module: `msi_ring_logger`

## Requirements
- R1: After reset every register reads zero, `msg_ready`, `mw_valid` and `irq_out` are low, and the size field selects the smallest ring.
- R2: Register word addresses are: 0 control, 3 base high, 4 base low, 5 read offset, 6 write offset. Other addresses read zero. The write offset is read-only, and writes to it are ignored. Control bits are: 0 enable, 1 full-detect enable, 3 interrupt enable, 4 stop-on-full, 9:8 size code, 15 overflow flag. Writing 1 to bit 15 clears the overflow flag.
- R3: Each accepted message that is not dropped produces one memory write. Its address is base + write offset. Data bits 31:0 hold the message in little-endian byte order, so byte lane k is bits 8k+7:8k and carries message bits 8k+7:8k. Data bits 127:32 are zero.
- R4: The write offset advances by 16 only when a memory write handshake completes. While `mw_ready` is low, `mw_valid`, `mw_addr` and `mw_data` hold steady. `msg_ready` is low while a write is pending.
- R5: The ring size is 2^(MIN_RING_LOG2 + code) bytes. Both offsets are masked to the ring size and to 16-byte alignment, so they wrap to zero past the end. A software write to the read offset is masked the same way.
- R6: With the enable bit clear, `msg_ready` is low and no message is taken.
- R7: With full-detect enabled, the ring is full when the write offset plus 16, wrapped, equals the read offset. In that state, with stop-on-full set, `msg_ready` stays low until software moves the read offset.
- R8: On a full ring with stop-on-full clear, a message is accepted, no memory write is issued, the write offset is unchanged, and bit 15 is set. If the flag is set and software clears it in the same cycle, the set takes priority.
- R9: With full-detect disabled, a message on a full ring is written normally, and the write offset advances onto the read offset.
- R10: `irq_out` is high exactly when interrupt enable is set and the write offset differs from the read offset. It responds in the cycle after the register that changes the comparison is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| msg_valid | input | 1 | Inbound message present |
| msg_ready | output | 1 | Block takes the message this cycle |
| msg_data | input | 32 | Inbound message data word |
| mw_valid | output | 1 | Memory write request valid |
| mw_ready | input | 1 | Memory accepts the request |
| mw_addr | output | 64 | Byte address of the entry |
| mw_data | output | 128 | Entry contents, byte lane k at bits 8k+7:8k |
| irq_out | output | 1 | Level interrupt: unread entries exist |

## Verification
The overflow flag has two writers that can act in the same clock. A message dropped on a full ring sets the flag, while a control write with bit 15 set clears it. The bench fills the ring with stop-on-full clear, then in one cycle presents a message and a control write that clears the flag. Reading control afterwards must show bit 15 still set, with no memory write issued. A second same-cycle case comes up in every ring-size sweep: the read-offset update and write-offset advances feed the same comparison, and `irq_out` is checked after each.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;

  localparam int MSG_W       = 32;
  localparam int REG_W       = 32;
  localparam int ADDR_W      = 64;
  localparam int ENTRY_BYTES = 16;
  localparam int ENTRY_W     = 8 * ENTRY_BYTES;
  localparam int RA_W        = 3;

  localparam logic [RA_W-1:0] RA_CTRL    = 3'h0;
  localparam logic [RA_W-1:0] RA_BASE_HI = 3'h3;
  localparam logic [RA_W-1:0] RA_BASE_LO = 3'h4;
  localparam logic [RA_W-1:0] RA_RD_OFF  = 3'h5;
  localparam logic [RA_W-1:0] RA_WR_OFF  = 3'h6;

  localparam int CB_EN       = 0;
  localparam int CB_FULL_DET = 1;
  localparam int CB_IRQ_EN   = 3;
  localparam int CB_STOP     = 4;
  localparam int CB_SIZE_LO  = 8;
  localparam int CB_OVF      = 15;

  localparam logic [REG_W-1:0] CTRL_RW_MASK = 32'h0000_031B;

  // Byte mask of a ring of 2^(min_log2+code) bytes, entry aligned.
  function automatic logic [REG_W-1:0] ring_mask(input int unsigned min_log2,
                                                 input logic [1:0] code);
    logic [REG_W-1:0] span;
    span = 32'd1 << (min_log2 + 32'(code));
    return (span - 32'd1) & ~32'(ENTRY_BYTES - 1);
  endfunction

  // Next entry offset, wrapped to the ring.
  function automatic logic [REG_W-1:0] step_off(input logic [REG_W-1:0] off,
                                                input logic [REG_W-1:0] mask);
    return (off + 32'(ENTRY_BYTES)) & mask;
  endfunction

endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
  import msi_ring_pkg::*;
#(
  parameter int unsigned MIN_RING_LOG2 = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              adv,
  input  logic              ovf_set,
  output logic              ctl_en,
  output logic              ctl_full_det,
  output logic              ctl_irq_en,
  output logic              ctl_stop,
  output logic [REG_W-1:0]  off_mask,
  output logic [ADDR_W-1:0] base,
  output logic [REG_W-1:0]  rd_off,
  output logic [REG_W-1:0]  wr_off,
  output logic              ovf_flag
);

  logic [REG_W-1:0] ctrl_q, base_hi_q, base_lo_q, rd_q, wr_q;
  logic             ovf_q;

  wire wr_ctrl = reg_we && (reg_addr == RA_CTRL);
  wire wr_bhi  = reg_we && (reg_addr == RA_BASE_HI);
  wire wr_blo  = reg_we && (reg_addr == RA_BASE_LO);
  wire wr_rd   = reg_we && (reg_addr == RA_RD_OFF);

  assign off_mask = ring_mask(MIN_RING_LOG2, ctrl_q[CB_SIZE_LO +: 2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      base_hi_q <= '0;
      base_lo_q <= '0;
      rd_q      <= '0;
      wr_q      <= '0;
      ovf_q     <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q    <= reg_wdata & CTRL_RW_MASK;
      if (wr_bhi)  base_hi_q <= reg_wdata;
      if (wr_blo)  base_lo_q <= reg_wdata;
      if (wr_rd)   rd_q      <= reg_wdata & off_mask;
      if (adv)     wr_q      <= step_off(wr_q, off_mask);
      // a fresh overflow outranks a simultaneous software clear
      if (ovf_set)                          ovf_q <= 1'b1;
      else if (wr_ctrl && reg_wdata[CB_OVF]) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata         = ctrl_q;
        reg_rdata[CB_OVF] = ovf_q;
      end
      RA_BASE_HI: reg_rdata = base_hi_q;
      RA_BASE_LO: reg_rdata = base_lo_q;
      RA_RD_OFF:  reg_rdata = rd_q;
      RA_WR_OFF:  reg_rdata = wr_q;
      default:    reg_rdata = '0;
    endcase
  end

  assign ctl_en       = ctrl_q[CB_EN];
  assign ctl_full_det = ctrl_q[CB_FULL_DET];
  assign ctl_irq_en   = ctrl_q[CB_IRQ_EN];
  assign ctl_stop     = ctrl_q[CB_STOP];
  assign base         = {base_hi_q, base_lo_q};
  assign rd_off       = rd_q;
  assign wr_off       = wr_q;
  assign ovf_flag     = ovf_q;

endmodule

// File: rtl/msi_ring_admit.sv
module msi_ring_admit
  import msi_ring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_en,
  input  logic             ctl_full_det,
  input  logic             ctl_stop,
  input  logic [REG_W-1:0] off_mask,
  input  logic [REG_W-1:0] rd_off,
  input  logic [REG_W-1:0] wr_off,
  input  logic             msg_valid,
  input  logic [MSG_W-1:0] msg_data,
  output logic             msg_ready,
  input  logic             drain,
  output logic             skid_valid,
  output logic [MSG_W-1:0] skid_data,
  output logic             ev_accept,
  output logic             ev_drop
);

  logic ring_full;

  assign ring_full = ctl_full_det && (step_off(wr_off, off_mask) == rd_off);
  assign msg_ready = ctl_en && !skid_valid && !(ring_full && ctl_stop);
  assign ev_accept = msg_valid && msg_ready;
  assign ev_drop   = ev_accept && ring_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skid_valid <= 1'b0;
      skid_data  <= '0;
    end else if (ev_accept && !ring_full) begin
      skid_valid <= 1'b1;
      skid_data  <= msg_data;
    end else if (drain) begin
      skid_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/msi_ring_emit.sv
module msi_ring_emit
  import msi_ring_pkg::*;
(
  input  logic                skid_valid,
  input  logic [MSG_W-1:0]    skid_data,
  input  logic [ADDR_W-1:0]   base,
  input  logic [REG_W-1:0]    wr_off,
  output logic                mw_valid,
  output logic [ADDR_W-1:0]   mw_addr,
  output logic [ENTRY_W-1:0]  mw_data
);

  localparam int MSG_BYTES = MSG_W / 8;

  assign mw_valid = skid_valid;
  assign mw_addr  = base + ADDR_W'(wr_off);

  for (genvar k = 0; k < ENTRY_BYTES; k++) begin : g_lane
    if (k < MSG_BYTES) begin : g_msg
      assign mw_data[8*k +: 8] = skid_data[8*k +: 8];
    end else begin : g_pad
      assign mw_data[8*k +: 8] = 8'h00;
    end
  end

endmodule

// File: rtl/msi_ring_logger.sv
module msi_ring_logger
  import msi_ring_pkg::*;
#(
  parameter int unsigned MIN_RING_LOG2 = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          msg_valid,
  output logic          msg_ready,
  input  logic [31:0]   msg_data,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [63:0]   mw_addr,
  output logic [127:0]  mw_data,
  output logic          irq_out
);

  logic              ctl_en, ctl_full_det, ctl_irq_en, ctl_stop, ovf_flag;
  logic [REG_W-1:0]  off_mask, rd_off, wr_off;
  logic [ADDR_W-1:0] base;
  logic              skid_valid;
  logic [MSG_W-1:0]  skid_data;
  logic              ev_accept, ev_drop, ev_advance;

  assign ev_advance = mw_valid && mw_ready;

  msi_ring_regs #(.MIN_RING_LOG2(MIN_RING_LOG2)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .adv         (ev_advance),
    .ovf_set     (ev_drop),
    .ctl_en      (ctl_en),
    .ctl_full_det(ctl_full_det),
    .ctl_irq_en  (ctl_irq_en),
    .ctl_stop    (ctl_stop),
    .off_mask    (off_mask),
    .base        (base),
    .rd_off      (rd_off),
    .wr_off      (wr_off),
    .ovf_flag    (ovf_flag)
  );

  msi_ring_admit u_admit (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_en      (ctl_en),
    .ctl_full_det(ctl_full_det),
    .ctl_stop    (ctl_stop),
    .off_mask    (off_mask),
    .rd_off      (rd_off),
    .wr_off      (wr_off),
    .msg_valid   (msg_valid),
    .msg_data    (msg_data),
    .msg_ready   (msg_ready),
    .drain       (ev_advance),
    .skid_valid  (skid_valid),
    .skid_data   (skid_data),
    .ev_accept   (ev_accept),
    .ev_drop     (ev_drop)
  );

  msi_ring_emit u_emit (
    .skid_valid(skid_valid),
    .skid_data (skid_data),
    .base      (base),
    .wr_off    (wr_off),
    .mw_valid  (mw_valid),
    .mw_addr   (mw_addr),
    .mw_data   (mw_data)
  );

  assign irq_out = ctl_irq_en && (wr_off != rd_off);

endmodule

// File: rtl/msi_ring_checker.sv
module msi_ring_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         msg_ready,
  input logic         mw_valid,
  input logic         mw_ready,
  input logic [63:0]  mw_addr,
  input logic [127:0] mw_data,
  input logic         irq_out,
  input logic         ctl_en,
  input logic         ctl_irq_en,
  input logic         ev_accept,
  input logic         ev_advance,
  input logic         ev_drop,
  input logic         ovf_flag,
  input logic [31:0]  wr_off,
  input logic [31:0]  rd_off
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data))); // R4

  AST_WR_OFF_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_advance |=> $stable(wr_off)); // R4

  AST_ONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> !msg_ready); // R4

  AST_TAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> !mw_valid); // R4

  AST_OFF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_off[3:0] == 4'h0) && (rd_off[3:0] == 4'h0)); // R5

  AST_DISABLED_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> !msg_ready); // R6

  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> (ovf_flag && !mw_valid)); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_irq_en |-> !irq_out); // R10

endmodule

bind msi_ring_logger msi_ring_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .msg_ready (msg_ready),
  .mw_valid  (mw_valid),
  .mw_ready  (mw_ready),
  .mw_addr   (mw_addr),
  .mw_data   (mw_data),
  .irq_out   (irq_out),
  .ctl_en    (ctl_en),
  .ctl_irq_en(ctl_irq_en),
  .ev_accept (ev_accept),
  .ev_advance(ev_advance),
  .ev_drop   (ev_drop),
  .ovf_flag  (ovf_flag),
  .wr_off    (wr_off),
  .rd_off    (rd_off)
);

// File: tb/msi_ring_logger_tb_top.sv
module msi_ring_logger_tb_top;

  localparam int unsigned MINL = 7;
  localparam logic [31:0] C_EN = 32'h1, C_FD = 32'h2, C_IE = 32'h8, C_SF = 32'h10, C_OVF = 32'h8000;
  localparam logic [63:0] BASE = 64'h0000_00AB_CDEF_1000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         msg_valid = 1'b0;
  logic         msg_ready;
  logic [31:0]  msg_data = '0;
  logic         mw_valid;
  logic         mw_ready = 1'b0;
  logic [63:0]  mw_addr;
  logic [127:0] mw_data;
  logic         irq_out;

  msi_ring_logger #(.MIN_RING_LOG2(MINL)) dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0]  q_addr[$];
  logic [127:0] q_data[$];
  logic         mem_hold = 1'b0;
  logic         stall_mode = 1'b0;
  int           cyc = 0;
  logic [31:0]  exp_wr = '0;
  logic [31:0]  rv;

  // memory responder: set ready, then log a handshake due at the next edge
  always @(negedge clk) begin
    cyc++;
    mw_ready = mem_hold ? 1'b0 : (stall_mode ? (cyc % 3 == 0) : 1'b1);
    #1;
    if (rst_n && mw_valid && mw_ready) begin
      q_addr.push_back(mw_addr);
      q_data.push_back(mw_data);
    end
  end

  function automatic logic [31:0] msk(input int code);
    return ((32'd1 << (MINL + code)) - 32'd1) & 32'hFFFF_FFF0;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2;
    d = reg_rdata;
  endtask

  task automatic send(input logic [31:0] d);
    @(negedge clk);
    msg_valid = 1'b1; msg_data = d;
    for (int t = 0; t < 200; t++) begin
      #2;
      if (msg_ready) begin
        @(negedge clk);
        msg_valid = 1'b0;
        return;
      end
      @(negedge clk);
    end
    msg_valid = 1'b0;
    check("R4 handshake timeout", 0, 1);
  endtask

  task automatic expect_write(input string tag, input logic [31:0] d);
    logic [127:0] ed;
    ed = '0;
    for (int k = 0; k < 4; k++) ed[8*k +: 8] = d[8*k +: 8];
    for (int t = 0; t < 60 && q_addr.size() == 0; t++) @(negedge clk);
    if (q_addr.size() == 0) begin
      check({tag, " no write"}, 0, 1);
    end else begin
      check({tag, " addr"}, 128'(q_addr.pop_front()), 128'(BASE + 64'(exp_wr)));
      check({tag, " data"}, q_data.pop_front(), ed);
    end
    exp_wr = (exp_wr + 32'd16) & msk(0 + ((reg_ctrl_code())));
  endtask

  logic [1:0] cur_code = 2'd0;
  function automatic int reg_ctrl_code();
    return int'(cur_code);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #2;
    check("R1 msg_ready", 128'(msg_ready), 0);
    check("R1 mw_valid", 128'(mw_valid), 0);
    check("R1 irq_out", 128'(irq_out), 0);
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), rv);
      check("R1 register zero", 128'(rv), 0);
    end
    // R2 map
    wr_reg(3'h3, BASE[63:32]);
    wr_reg(3'h4, BASE[31:0]);
    rd_reg(3'h3, rv); check("R2 base hi", 128'(rv), 128'(BASE[63:32]));
    rd_reg(3'h4, rv); check("R2 base lo", 128'(rv), 128'(BASE[31:0]));
    wr_reg(3'h6, 32'h40);
    rd_reg(3'h6, rv); check("R2 write offset read-only", 128'(rv), 0);
    wr_reg(3'h1, 32'hFFFF_FFFF);
    rd_reg(3'h1, rv); check("R2 unmapped reads zero", 128'(rv), 0);
    wr_reg(3'h0, 32'hFFFF_7FFF);
    rd_reg(3'h0, rv); check("R2 control writable bits", 128'(rv), 128'h31B);
    // R4 pending write held under back-pressure
    wr_reg(3'h0, C_EN | C_FD | C_IE);
    mem_hold = 1'b1;
    send(32'h1234_ABCD);
    repeat (3) @(negedge clk);
    #2;
    check("R4 pending valid", 128'(mw_valid), 1);
    check("R4 busy not ready", 128'(msg_ready), 0);
    check("R3 addr", 128'(mw_addr), 128'(BASE));
    check("R3 data", mw_data, 128'h1234_ABCD);
    rd_reg(3'h6, rv); check("R4 no advance before handshake", 128'(rv), 0);
    mem_hold = 1'b0;
    expect_write("R3 first entry", 32'h1234_ABCD);
    rd_reg(3'h6, rv); check("R4 advance by 16", 128'(rv), 128'(exp_wr));
    check("R10 irq on unread", 128'(irq_out), 1);
    wr_reg(3'h5, exp_wr);
    #2; check("R10 irq off when caught up", 128'(irq_out), 0);
    // R5 wrap sweep across all sizes
    for (int c = 0; c < 4; c++) begin
      cur_code = 2'(c);
      stall_mode = c[0];
      wr_reg(3'h0, C_EN | C_FD | C_IE | (32'(c) << 8));
      for (int i = 0; i < 2 * (8 << c); i++) begin
        logic [31:0] d;
        d = {8'hC0 + 8'(c), 8'(i * 7), 16'(i)};
        send(d);
        expect_write("R5 sweep", d);
        rd_reg(3'h6, rv); check("R5 wrapped write offset", 128'(rv), 128'(exp_wr));
        check("R10 irq pending", 128'(irq_out), 1);
        wr_reg(3'h5, exp_wr);
      end
    end
    stall_mode = 1'b0;
    // R5 masked read offset writes
    wr_reg(3'h5, 32'hFFFF_FFFF);
    rd_reg(3'h5, rv); check("R5 rd mask code3", 128'(rv), 128'(msk(3)));
    cur_code = 2'd0;
    wr_reg(3'h0, C_EN | C_FD | C_IE | C_SF);
    wr_reg(3'h5, 32'hFFFF_FFFF);
    rd_reg(3'h5, rv); check("R5 rd mask code0", 128'(rv), 128'(msk(0)));
    wr_reg(3'h5, exp_wr);
    // R7 fill to full with stop-on-full
    for (int i = 0; i < 7; i++) begin
      send(32'h7700 + 32'(i));
      expect_write("R7 fill", 32'h7700 + 32'(i));
    end
    @(negedge clk);
    msg_valid = 1'b1; msg_data = 32'h0000_BEEF;
    repeat (5) @(negedge clk);
    #2;
    check("R7 stalled when full", 128'(msg_ready), 0);
    check("R7 no write when full", 128'(q_addr.size()), 0);
    rd_reg(3'h5, rv);
    wr_reg(3'h5, (rv + 32'd16) & msk(0));
    #2;
    check("R7 ready after space", 128'(msg_ready), 1);
    @(negedge clk);
    msg_valid = 1'b0;
    expect_write("R7 released entry", 32'h0000_BEEF);
    // R8 drop with overflow flag
    wr_reg(3'h0, C_EN | C_FD | C_IE);
    send(32'hDEAD_0001);
    repeat (4) @(negedge clk);
    check("R8 dropped no write", 128'(q_addr.size()), 0);
    rd_reg(3'h6, rv); check("R8 offset unchanged", 128'(rv), 128'(exp_wr));
    rd_reg(3'h0, rv); check("R8 overflow set", 128'(rv), 128'(C_EN | C_FD | C_IE | C_OVF));
    wr_reg(3'h0, C_EN | C_FD | C_IE | C_OVF);
    rd_reg(3'h0, rv); check("R8 overflow cleared", 128'(rv), 128'(C_EN | C_FD | C_IE));
    @(negedge clk);
    msg_valid = 1'b1; msg_data = 32'hDEAD_0002;
    reg_we = 1'b1; reg_addr = 3'h0; reg_wdata = C_EN | C_FD | C_IE | C_OVF;
    #2;
    check("R8 same-cycle ready", 128'(msg_ready), 1);
    @(negedge clk);
    msg_valid = 1'b0; reg_we = 1'b0;
    rd_reg(3'h0, rv); check("R8 set beats clear", 128'(rv), 128'(C_EN | C_FD | C_IE | C_OVF));
    check("R8 same-cycle no write", 128'(q_addr.size()), 0);
    // R9 full-detect off
    wr_reg(3'h0, C_EN | C_IE | C_OVF);
    rd_reg(3'h0, rv); check("R9 control", 128'(rv), 128'(C_EN | C_IE));
    send(32'h0909_0909);
    expect_write("R9 written on full ring", 32'h0909_0909);
    rd_reg(3'h6, rv); check("R9 offset advanced", 128'(rv), 128'(exp_wr));
    check("R9 irq low when offsets meet", 128'(irq_out), 0);
    // R6 disabled
    wr_reg(3'h0, C_IE);
    @(negedge clk);
    msg_valid = 1'b1; msg_data = 32'h0606_0606;
    repeat (5) @(negedge clk);
    #2;
    check("R6 not ready disabled", 128'(msg_ready), 0);
    msg_valid = 1'b0;
    check("R6 no write disabled", 128'(q_addr.size()), 0);
    rd_reg(3'h6, rv); check("R6 offset unchanged", 128'(rv), 128'(exp_wr));
    // R10 interrupt gating
    wr_reg(3'h0, C_EN | C_FD | C_IE);
    send(32'h1010_1010);
    expect_write("R10 entry", 32'h1010_1010);
    #2; check("R10 irq high", 128'(irq_out), 1);
    wr_reg(3'h0, C_EN | C_FD);
    #2; check("R10 irq masked", 128'(irq_out), 0);
    wr_reg(3'h0, C_EN | C_FD | C_IE);
    #2; check("R10 irq unmasked", 128'(irq_out), 1);
    wr_reg(3'h5, exp_wr);
    #2; check("R10 irq cleared by read offset", 128'(irq_out), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule